// File: doc/BRIEF.md
# Interruptible Iterative Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor. It produces a 16-bit quotient and a 16-bit remainder. It handles signed and unsigned operands, in integer form and in fractional 1.15 form. The work is split into a fixed sequence of single-cycle operations:

- one setup operation, on the edge that accepts `start`, captures the operand magnitudes and the result signs;
- sixteen restoring steps each produce one quotient bit;
- two closing operations correct the sign of the quotient and then of the remainder.

An uninterrupted divide therefore takes 19 clock edges, counting the start edge.

The complete working state is held in registers. This state is the partial remainder, the quotient being built (it shares a register with the dividend bits not yet consumed), the magnitude of the divisor, the sign flags and the step counter. The sequence advances only on edges where `step_en` is high and `hold` is low. A caller can therefore stall a divide for any number of cycles and resume it with no loss of data, much like an instruction that repeats one step at a time. All pins are plain control and status levels. There is no handshake: a new divide is started by a one-cycle `start` pulse while idle, and the result is read once `done` pulses.

Top module: `iter_divider`

## Requirements
- R1: During reset and right after it, `busy`, `done` and `div_err` are 0, and `quotient` and `remainder` are 0.
- R2: `start` is accepted only while `busy` is 0, and `busy` is 1 from the next cycle. A `start` that arrives while busy is ignored, and the running divide finishes with its original operands.
- R3: When `step_en` is 1 and `hold` is 0 throughout, `done` rises on the 19th clock edge, counting the edge that accepted `start` as the first.
- R4: Narrow integer mode (`mode_wide`=0, `mode_frac`=0) divides `dividend[15:0]` by `divisor` and ignores `dividend[31:16]`. The operands are two's complement when `mode_signed`=1 and unsigned when it is 0. The quotient is truncated toward zero.
- R5: Wide integer mode (`mode_wide`=1, `mode_frac`=0) divides the full 32-bit dividend by `divisor`. This requires the magnitude of the quotient to fit the 16-bit result.
- R6: Fractional mode (`mode_frac`=1, `mode_wide` ignored) treats `dividend[15:0]` and `divisor` as 1.15 values (0.16 when unsigned). It returns the quotient as dividend×2^15/divisor. This requires |dividend| < |divisor|. The case −0.5 / −1.0 gives 0x4000.
- R7: In signed mode, the quotient is negative exactly when the operand signs differ, and a non-zero remainder has the sign of the dividend.
- R8: On an edge where `hold` is 1, the quotient, remainder, step count and `busy` do not change. Each held edge delays `done` by one cycle.
- R9: While busy, an edge where `step_en` is 0 freezes the state in the same way as `hold`.
- R10: `done` is high for exactly one cycle. `busy` falls on the same edge that raises `done`.
- R11: A zero divisor sets `div_err` on the accepting edge, and the quotient is then undefined. `div_err` changes only when a new `start` is accepted.
- R12: After `done`, the results stay unchanged until the next accepted `start`, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divide when idle |
| step_en | input | 1 | Allows the sequence to advance |
| hold | input | 1 | Freezes the sequence when high |
| mode_wide | input | 1 | 1: 32/16 integer, 0: 16/16 |
| mode_signed | input | 1 | 1: two's complement operands |
| mode_frac | input | 1 | 1: fractional 1.15 division |
| dividend | input | 32 | Dividend, captured on start |
| divisor | input | 16 | Divisor, captured on start |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last divide had a zero divisor |
| quotient | output | 16 | Quotient (partial while busy) |
| remainder | output | 16 | Remainder (partial while busy) |

## Verification
The properties check only sequencing and freezing, so they place no limits on `start`, `hold` or `step_en`. Any mix of pauses and stray start pulses is legal.

The properties do take for granted that operands meet the range rules for results: the quotient fits 16 bits in wide mode, and the dividend magnitude is below the divisor magnitude in fractional mode. Those ranges are not checked in hardware. Every vector in the stimulus was chosen to satisfy them, and the only out-of-range case driven is the zero divisor, for which only the flag is compared.

// File: rtl/div_pkg.sv
package div_pkg;
  // Operation performed by the datapath on the current edge
  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_STEP,
    OP_FIXQ,
    OP_FIXR
  } div_op_e;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    step_en,
  input  logic    hold,
  output logic    busy,
  output logic    done,
  output div_op_e op
);
  localparam int PHASES = W + 2;            // steps plus two sign fixes
  localparam int CW     = $clog2(PHASES + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    op = OP_NONE;
    if (!busy && start)
      op = OP_LOAD;
    else if (busy && step_en && !hold) begin
      if (cnt < CW'(W))       op = OP_STEP;
      else if (cnt == CW'(W)) op = OP_FIXQ;
      else                    op = OP_FIXR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      unique case (op)
        OP_LOAD: begin
          busy <= 1'b1;
          cnt  <= '0;
        end
        OP_STEP, OP_FIXQ: cnt <= cnt + 1'b1;
        OP_FIXR: begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/div_prep.sv
module div_prep #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           wide,
  input  logic           sgn,
  input  logic           frac,
  output logic [2*W-1:0] num_mag,
  output logic [W-1:0]   den_mag,
  output logic           neg_q,
  output logic           neg_r,
  output logic           den_zero
);
  logic [2*W-1:0] n_ext;
  logic [2*W-1:0] n_abs;
  logic           n_neg;
  logic           d_neg;

  always_comb begin
    if (wide && !frac)
      n_ext = dividend;
    else if (sgn)
      n_ext = {{W{dividend[W-1]}}, dividend[W-1:0]};
    else
      n_ext = {{W{1'b0}}, dividend[W-1:0]};
    n_neg   = sgn & n_ext[2*W-1];
    n_abs   = n_neg ? (~n_ext + (2*W)'(1)) : n_ext;
    num_mag = frac ? (n_abs << (W-1)) : n_abs;
    d_neg   = sgn & divisor[W-1];
    den_mag = d_neg ? (~divisor + W'(1)) : divisor;
    neg_q   = n_neg ^ d_neg;
    neg_r   = n_neg;
    den_zero = (divisor == '0);
  end
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] den,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] quo_out
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    trial   = {rem_in, quo_in[W-1]};
    diff    = trial - {1'b0, den};
    fits    = (trial >= {1'b0, den});
    rem_out = fits ? diff[W-1:0] : trial[W-1:0];
    quo_out = {quo_in[W-2:0], fits};
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           step_en,
  input  logic           hold,
  input  logic           mode_wide,
  input  logic           mode_signed,
  input  logic           mode_frac,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic           div_err,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder
);
  div_op_e        op;
  logic [2*W-1:0] num_mag;
  logic [W-1:0]   den_mag;
  logic           p_neg_q, p_neg_r, p_zero;
  logic [W-1:0]   rem_r, quo_r, den_r;
  logic [W-1:0]   rem_n, quo_n;
  logic           neg_q_r, neg_r_r, err_r;

  div_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en),
    .hold(hold), .busy(busy), .done(done), .op(op)
  );

  div_prep #(.W(W)) u_prep (
    .dividend(dividend), .divisor(divisor), .wide(mode_wide),
    .sgn(mode_signed), .frac(mode_frac), .num_mag(num_mag),
    .den_mag(den_mag), .neg_q(p_neg_q), .neg_r(p_neg_r), .den_zero(p_zero)
  );

  div_step_unit #(.W(W)) u_step (
    .rem_in(rem_r), .quo_in(quo_r), .den(den_r),
    .rem_out(rem_n), .quo_out(quo_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_r   <= '0;
      quo_r   <= '0;
      den_r   <= '0;
      neg_q_r <= 1'b0;
      neg_r_r <= 1'b0;
      err_r   <= 1'b0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          rem_r   <= num_mag[2*W-1:W];
          quo_r   <= num_mag[W-1:0];
          den_r   <= den_mag;
          neg_q_r <= p_neg_q;
          neg_r_r <= p_neg_r;
          err_r   <= p_zero;
        end
        OP_STEP: begin
          rem_r <= rem_n;
          quo_r <= quo_n;
        end
        OP_FIXQ: if (neg_q_r) quo_r <= W'(0) - quo_r;
        OP_FIXR: if (neg_r_r) rem_r <= W'(0) - rem_r;
        default: ;
      endcase
    end
  end

  assign quotient  = quo_r;
  assign remainder = rem_r;
  assign div_err   = err_r;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         step_en,
  input logic         hold,
  input logic         busy,
  input logic         done,
  input logic         div_err,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && !done); // R2

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hold |=> busy && $stable(quotient) && $stable(remainder)); // R8

  AST_STEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step_en |=> busy && $stable(quotient) && $stable(remainder)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R10

  AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(!busy && start) |=> $stable(div_err)); // R11

  AST_IDLE_RESULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(quotient) && $stable(remainder)); // R12
endmodule

bind iter_divider div_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en), .hold(hold),
  .busy(busy), .done(done), .div_err(div_err),
  .quotient(quotient), .remainder(remainder)
);

// File: tb/tb_iter_divider.sv
module tb_iter_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [31:0] dvd;
    logic [15:0] dvs;
    logic        wide;
    logic        sgn;
    logic        frac;
    logic [15:0] q;
    logic [15:0] r;
  } vec_t;

  // dividend, divisor, wide, signed, frac, expected quotient, expected remainder
  localparam vec_t VECS [NV] = '{
    '{32'd1000,     16'd7,    1'b0, 1'b0, 1'b0, 16'd142,  16'd6},   // R4
    '{32'h0000FC18, 16'd7,    1'b0, 1'b1, 1'b0, 16'hFF72, 16'hFFFA},// R4 R7
    '{32'd1000,     16'hFFF9, 1'b0, 1'b1, 1'b0, 16'hFF72, 16'h0006},// R7
    '{32'h0000FC18, 16'hFFF9, 1'b0, 1'b1, 1'b0, 16'h008E, 16'hFFFA},// R7
    '{32'h00008000, 16'h0002, 1'b0, 1'b1, 1'b0, 16'hC000, 16'h0000},// R4
    '{32'hABCD0064, 16'd10,   1'b0, 1'b0, 1'b0, 16'd10,   16'd0},   // R4 upper half ignored
    '{32'h000F4240, 16'h03E8, 1'b1, 1'b0, 1'b0, 16'h03E8, 16'h0000},// R5
    '{32'h12345678, 16'hFFFF, 1'b1, 1'b0, 1'b0, 16'h1234, 16'h68AC},// R5
    '{32'hFFF0BDC0, 16'h03E8, 1'b1, 1'b1, 1'b0, 16'hFC18, 16'h0000},// R5 R7
    '{32'hFFF0BDBD, 16'h03E8, 1'b1, 1'b1, 1'b0, 16'hFC18, 16'hFFFD},// R5 R7
    '{32'h000F4240, 16'hFC18, 1'b1, 1'b1, 1'b0, 16'hFC18, 16'h0000},// R5 R7
    '{32'h00002000, 16'h4000, 1'b0, 1'b1, 1'b1, 16'h4000, 16'h0000},// R6
    '{32'h0000E000, 16'h4000, 1'b0, 1'b1, 1'b1, 16'hC000, 16'h0000},// R6 R7
    '{32'h0000C000, 16'h8000, 1'b1, 1'b1, 1'b1, 16'h4000, 16'h0000},// R6 -0.5/-1.0
    '{32'h00000001, 16'h0003, 1'b0, 1'b1, 1'b1, 16'h2AAA, 16'h0002},// R6
    '{32'h00008000, 16'hC000, 1'b0, 1'b0, 1'b1, 16'h5555, 16'h4000} // R6 unsigned
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        step_en = 1'b1;
  logic        hold = 1'b0;
  logic        mode_wide = 1'b0;
  logic        mode_signed = 1'b0;
  logic        mode_frac = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, div_err;
  logic [15:0] quotient, remainder;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  iter_divider dut (
    .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en), .hold(hold),
    .mode_wide(mode_wide), .mode_signed(mode_signed), .mode_frac(mode_frac),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .div_err(div_err), .quotient(quotient), .remainder(remainder)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drives one start pulse; returns at the negedge after the accepting edge.
  task automatic launch(input logic [31:0] dvd, input logic [15:0] dvs,
                        input logic w, input logic s, input logic f);
    @(negedge clk);
    dividend = dvd; divisor = dvs;
    mode_wide = w; mode_signed = s; mode_frac = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Counts negedges until done is seen.
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] q0, r0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !div_err && quotient == 0 && remainder == 0,
          "R1", "reset state", {busy, done, div_err, quotient[0]}, 0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      launch(VECS[i].dvd, VECS[i].dvs, VECS[i].wide, VECS[i].sgn, VECS[i].frac);
      check(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
      wait_done(n);
      check(n + 1 == 19, "R3", "edges to done", n + 1, 19);
      check(quotient == VECS[i].q, "R4 R5 R6 R7", $sformatf("quotient vec %0d", i),
            quotient, VECS[i].q);
      check(remainder == VECS[i].r, "R4 R5 R6 R7", $sformatf("remainder vec %0d", i),
            remainder, VECS[i].r);
      check(!busy && !div_err, "R10", "busy dropped with done", {busy, div_err}, 0);
      @(negedge clk);
      check(!done, "R10", "done single cycle", 32'(done), 0);
    end

    // R12: results held while idle inputs wander
    q0 = quotient; r0 = remainder;
    dividend = 32'hDEADBEEF; divisor = 16'h0001; mode_signed = 1'b0;
    repeat (4) @(negedge clk);
    check(quotient == q0 && remainder == r0, "R12", "idle results kept",
          {quotient, remainder}, {q0, r0});

    // R8 and R9: pause with hold then with step_en low
    launch(32'd1000, 16'd7, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    hold = 1'b1;
    q0 = quotient; r0 = remainder;
    repeat (3) @(negedge clk);
    check(busy && quotient == q0 && remainder == r0, "R8", "hold freezes state",
          {quotient, remainder}, {q0, r0});
    hold = 1'b0; step_en = 1'b0;
    repeat (2) @(negedge clk);
    check(busy && quotient == q0 && remainder == r0, "R9", "step_en low freezes",
          {quotient, remainder}, {q0, r0});
    step_en = 1'b1;
    wait_done(n);
    check(n == 15, "R8", "done delayed by paused edges", n, 15);
    check(quotient == 16'd142 && remainder == 16'd6, "R8", "result after pause",
          {quotient, remainder}, {16'd142, 16'd6});

    // R2: start while busy is ignored
    launch(32'h000F4240, 16'h03E8, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    dividend = 32'd1000; divisor = 16'd7; mode_wide = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    check(n == 16, "R2", "run length unchanged by stray start", n, 16);
    check(quotient == 16'h03E8 && remainder == 16'h0, "R2", "stray start ignored",
          {quotient, remainder}, {16'h03E8, 16'h0});

    // R11: zero divisor flag, cleared by next start
    launch(32'd1000, 16'd0, 1'b0, 1'b0, 1'b0);
    check(div_err == 1'b1, "R11", "flag on accepting edge", 32'(div_err), 1);
    wait_done(n);
    check(div_err == 1'b1, "R11", "flag held at done", 32'(div_err), 1);
    launch(32'd1000, 16'd7, 1'b0, 1'b0, 1'b0);
    check(div_err == 1'b0, "R11", "flag cleared by new start", 32'(div_err), 0);

    // R1: reset in the middle of a divide
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && !div_err && quotient == 0 && remainder == 0,
          "R1", "mid-run reset", {busy, quotient, remainder}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule